// File: doc/BRIEF.md
# Watch Interval Timer with Buzzer Tap

The block keeps time from a slow source clock. A free-running binary prescaler counts strobes of the chosen source. A rising edge on one of its upper bits raises a sticky interval flag. In normal mode this bit gives a half-second interval from a 32.768 kHz source. A debug fast mode uses a lower bit, which makes the interval 128 times shorter. The same prescaler also supplies three taps for a buzzer pin. The buzzer output is gated by an enable bit and by the port output latch.

The source clock is not wired into the block as a clock. Instead, two strobe inputs each mark one edge of a candidate source, so a strobe arrives at twice the source frequency fW. With this convention prescaler bit k is a square wave at fW/2^k. Bit 0 therefore carries fW itself, bit 14 carries fW/2^14 and bit 7 carries fW/2^7. One strobe input comes from the 32.768 kHz subsystem clock and the other from the main clock divided by 128.

Software uses the following controls:
- An 8-bit control register, which it writes and reads back.
- A strobe that clears the prescaler, so timekeeping restarts at zero.
- A strobe that clears the flag.

The flag also drives a wake request for releasing standby.

Top module: `watch_tick_timer`

## Requirements
- R1: The prescaler advances by one on each strobe of the selected source. Control bit 2 selects the source: 1 takes `sub_tick`, 0 takes `main_tick`. Strobes of the unselected source have no effect.
- R2: In normal mode (control bit 1 = 0), bit 14 of the prescaler is the interval tap. The flag becomes 1 two cycles after the step that makes this bit rise, which happens once per 2^15 strobes.
- R3: In fast mode (control bit 1 = 1), bit 7 of the prescaler is the interval tap. The flag becomes 1 two cycles after the step that makes this bit rise, which happens once per 2^8 strobes.
- R4: A tap rise leaves the flag unchanged while the enable bit (control bit 0) is 0.
- R5: The flag stays 1 until `flag_clr` is pulsed, and the clear takes effect one cycle after the pulse. When a clear and a set event fall in the same cycle, the flag stays 1.
- R6: `wake_req` equals the flag in every cycle.
- R7: A pulse on `div_clr` sets the whole prescaler to zero at the next edge. This takes priority over a strobe in the same cycle.
- R8: While `main_div_active` is 1, a write that would set control bit 2 from 0 to 1 leaves bit 2 unchanged.
- R9: Control bits 4:3 choose the buzzer tap: 00 gives fW/2^4 (prescaler bit 4), 01 gives fW/2^3 (bit 3), and 10 or 11 gives fW (bit 0). `buz_pin` is registered, so it shows the tap one cycle after the prescaler changes.
- R10: `buz_pin` carries the tap only when control bit 5 and `port_latch` are both 1. Otherwise it carries `port_latch`.
- R11: `ctl_rdata` is registered one cycle behind the register state:
  - bits 5:0 return the stored control bits;
  - bit 6 reads 0;
  - bit 7 returns the current level of the selected interval tap.
- R12: After reset the flag, the wake request, all control bits and the prescaler are 0, and `buz_pin` follows `port_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Edge strobe of the 32.768 kHz subsystem source |
| main_tick | input | 1 | Edge strobe of the divided main-clock source |
| main_div_active | input | 1 | The CPU runs from the divided main clock |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback with tap status |
| div_clr | input | 1 | Prescaler clear strobe |
| flag_clr | input | 1 | Interval flag clear strobe |
| irq_flag | output | 1 | Sticky interval flag |
| wake_req | output | 1 | Standby release request |
| port_latch | input | 1 | Port output latch value |
| buz_pin | output | 1 | Buzzer or port pin level |

## Verification
Every check is timed in cycles from a prescaler clear, which puts the count at zero at a known edge.

| Result | Due at the sample after edge |
|---|---|
| Flag for a tap rise that lands at count c0+N | c0+N+2 |
| `buz_pin` bit k | c0+m, as bit k of count m-1 |
| `ctl_rdata` bit 7 | c0+m, as bit k of count m-1 |
| Control field write | the second sample after the write |

The driver pushes each expected flag cycle into a queue before the flag can rise. A monitor samples at the falling edge, pops the queue on every flag rise and compares the cycle number.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CTL_W = 6;

  typedef struct packed {
    logic       buz_en;   // bit 5
    logic [1:0] buz_sel;  // bits 4:3
    logic       src_sub;  // bit 2
    logic       fast;     // bit 1
    logic       en;       // bit 0
  } wt_ctl_t;

  localparam logic [1:0] BUZ_SEL_DIV16 = 2'b00;
  localparam logic [1:0] BUZ_SEL_DIV8  = 2'b01;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (step)
      cnt <= cnt + 1'b1;
  end

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  assert_step_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> (cnt == $past(cnt) + 1'b1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt));
endmodule

// File: rtl/wt_edge_pulse.sv
module wt_edge_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      level_q <= level;
      pulse   <= level & ~level_q;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/wt_buzz_mux.sv
module wt_buzz_mux #(
  parameter int NTAP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NTAP-1:0] taps,     // [0]=fW/16 [1]=fW/8 [2]=fW
  input  logic [1:0]      sel,
  input  logic            en,
  input  logic            latch,
  output logic            pin
);
  import wt_pkg::*;
  logic tap_sel;

  always_comb begin
    case (sel)
      BUZ_SEL_DIV16: tap_sel = taps[0];
      BUZ_SEL_DIV8:  tap_sel = taps[1];
      default:       tap_sel = taps[NTAP-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      pin <= 1'b0;
    else
      pin <= (en && latch) ? tap_sel : latch;
  end

  assert_gate_low_R10: assert property (@(posedge clk) disable iff (rst)
    !latch |=> !pin);
  assert_gate_pass_R10: assert property (@(posedge clk) disable iff (rst)
    (latch && !en) |=> pin);
endmodule

// File: rtl/watch_tick_timer.sv
module watch_tick_timer #(
  parameter int PRE_W    = 15,
  parameter int SLOW_BIT = 14,
  parameter int FAST_BIT = 7,
  parameter int BUZ_LO   = 4,
  parameter int BUZ_MID  = 3,
  parameter int BUZ_HI   = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sub_tick,
  input  logic       main_tick,
  input  logic       main_div_active,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       div_clr,
  input  logic       flag_clr,
  output logic       irq_flag,
  output logic       wake_req,
  input  logic       port_latch,
  output logic       buz_pin
);
  import wt_pkg::*;

  localparam int NTAP = 3;

  wt_ctl_t          ctl_q;
  logic             step;
  logic [PRE_W-1:0] cnt;
  logic             tap_lvl;
  logic             set_evt;
  logic [NTAP-1:0]  buz_taps;

  // control register; the subsystem source is refused while on the divided main clock
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q.en      <= ctl_wdata[0];
      ctl_q.fast    <= ctl_wdata[1];
      ctl_q.buz_sel <= ctl_wdata[4:3];
      ctl_q.buz_en  <= ctl_wdata[5];
      if (!(main_div_active && ctl_wdata[2] && !ctl_q.src_sub))
        ctl_q.src_sub <= ctl_wdata[2];
    end
  end

  assign step = ctl_q.src_sub ? sub_tick : main_tick;

  wt_prescaler #(.W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .clr  (div_clr),
    .cnt  (cnt)
  );

  assign tap_lvl = ctl_q.fast ? cnt[FAST_BIT] : cnt[SLOW_BIT];

  wt_edge_pulse u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (tap_lvl),
    .pulse (set_evt)
  );

  // sticky flag; a set event wins over a clear
  always_ff @(posedge clk) begin
    if (rst)
      irq_flag <= 1'b0;
    else if (set_evt && ctl_q.en)
      irq_flag <= 1'b1;
    else if (flag_clr)
      irq_flag <= 1'b0;
  end

  assign wake_req = irq_flag;

  always_ff @(posedge clk) begin
    if (rst)
      ctl_rdata <= '0;
    else
      ctl_rdata <= {tap_lvl, 1'b0, ctl_q};
  end

  assign buz_taps = {cnt[BUZ_HI], cnt[BUZ_MID], cnt[BUZ_LO]};

  wt_buzz_mux #(.NTAP(NTAP)) u_buz (
    .clk   (clk),
    .rst   (rst),
    .taps  (buz_taps),
    .sel   (ctl_q.buz_sel),
    .en    (ctl_q.buz_en),
    .latch (port_latch),
    .pin   (buz_pin)
  );

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (set_evt && ctl_q.en) |=> irq_flag);
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !set_evt) |=> !irq_flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !flag_clr) |=> irq_flag);
  assert_gated_R4: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.en |=> !$rose(irq_flag));
  assert_src_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (main_div_active && !ctl_q.src_sub) |=> !ctl_q.src_sub);
  assert_wake_R6: assert property (@(posedge clk) disable iff (rst)
    wake_req == irq_flag);
endmodule

// File: tb/tb_watch_tick_timer.sv
module tb_watch_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sub_tick = 1'b1;
  logic       main_tick = 1'b0;
  logic       main_div_active = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       div_clr = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq_flag;
  logic       wake_req;
  logic       port_latch = 1'b0;
  logic       buz_pin;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int c0 = 0;
  int exp_q[$];
  logic flag_prev = 1'b0;
  logic done = 1'b0;

  watch_tick_timer dut (
    .clk(clk), .rst(rst), .sub_tick(sub_tick), .main_tick(main_tick),
    .main_div_active(main_div_active), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .div_clr(div_clr), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .wake_req(wake_req), .port_latch(port_latch),
    .buz_pin(buz_pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: every flag rise is matched against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && irq_flag && !flag_prev) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2/R3 unexpected flag rise actual=%0d expected=none", cyc);
      end else begin
        chk("R2/R3 flag rise cycle", cyc, exp_q.pop_front());
      end
    end
    flag_prev = irq_flag;
  end

  always @(negedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clr();
    @(negedge clk); div_clr = 1'b1;
    @(negedge clk); div_clr = 1'b0; c0 = cyc;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic fclr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    logic b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 flag", irq_flag, 0);
    chk("R12 wake", wake_req, 0);
    chk("R12 rdata", ctl_rdata, 0);
    chk("R12 buz follows latch", buz_pin, 0);

    // R1: main source selected, main_tick idle, sub_tick strobing -> no count
    wr(8'h03);
    do_clr();
    wait_to(c0 + 300);
    chk("R1 unselected source ignored", ctl_rdata[7], 0);

    // R3 fast mode, R5 clear, R6 wake
    wr(8'h07);
    chk("R11 readback bits", ctl_rdata[6:0], 7);
    do_clr();
    exp_q.push_back(c0 + 130);
    exp_q.push_back(c0 + 386);
    wait_to(c0 + 128);
    chk("R11 tap status low", ctl_rdata[7], 0);
    @(negedge clk);
    chk("R11 tap status high", ctl_rdata[7], 1);
    wait_to(c0 + 200);
    fclr();
    chk("R5 clear", irq_flag, 0);
    chk("R6 wake low", wake_req, 0);
    wait_to(c0 + 390);
    chk("R5 sticky", irq_flag, 1);
    chk("R6 wake high", wake_req, 1);
    // R5 coincident clear and set
    wait_to(c0 + 641);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R5 set wins over clear", irq_flag, 1);
    wait_to(c0 + 700);
    fclr();
    chk("R5 clear after", irq_flag, 0);
    // R4 enable off: rise at c0+898 must not set
    wr(8'h06);
    wait_to(c0 + 1000);
    chk("R4 gated flag", irq_flag, 0);

    // R2 normal interval
    wr(8'h05);
    do_clr();
    exp_q.push_back(c0 + 16386);
    wait_to(c0 + 16390);
    chk("R2 normal flag", irq_flag, 1);
    fclr();

    // R7 clear mid count restarts timing
    wr(8'h07);
    do_clr();
    wait_to(c0 + 100);
    do_clr();
    exp_q.push_back(c0 + 130);
    wait_to(c0 + 140);
    chk("R7 restart timing", irq_flag, 1);
    fclr();
    wr(8'h06);

    // R8 source lock
    main_div_active = 1'b1;
    wr(8'h02);
    chk("R8 main allowed", ctl_rdata[2], 0);
    wr(8'h06);
    chk("R8 sub refused", ctl_rdata[2], 0);
    main_div_active = 1'b0;
    wr(8'h06);
    chk("R8 sub accepted", ctl_rdata[2], 1);
    wr(8'hFE);
    chk("R11 reserved bit", ctl_rdata[6], 0);

    // R9 buzzer taps, R10 gating
    port_latch = 1'b1;
    wr(8'h24);
    do_clr();
    wait_to(c0 + 16);
    chk("R9 div16 low", buz_pin, 0);
    @(negedge clk);
    chk("R9 div16 high", buz_pin, 1);
    wr(8'h2C);
    do_clr();
    wait_to(c0 + 8);
    chk("R9 div8 low", buz_pin, 0);
    @(negedge clk);
    chk("R9 div8 high", buz_pin, 1);
    wr(8'h34);
    b0 = buz_pin;
    @(negedge clk);
    chk("R9 fW toggles", buz_pin, !b0);
    port_latch = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 latch low", buz_pin, 0);
    @(negedge clk);
    chk("R10 latch low hold", buz_pin, 0);
    port_latch = 1'b1;
    wr(8'h14);
    chk("R10 enable off", buz_pin, 1);
    @(negedge clk);
    chk("R10 enable off hold", buz_pin, 1);

    chk("R2/R3 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule